// File: doc/BRIEF.md
# Debug Break Control Register with Trigger Pulse

This block holds the 32-bit control and status word of a debug break unit and drives a single trigger output. A bus port writes the configuration fields and a read port returns the register at all times. Four break-match event inputs, each pulsed for one cycle by the comparators outside this block, set sticky flags. Software clears a flag with a write-zero protocol: a written 0 clears a flag and a written 1 leaves it as it was. So one flag is cleared by writing 0 to it and 1 to the others.

Any break event also starts a pulse on the trigger output. The pulse lasts a power-of-two number of bus clock cycles, picked by a 2-bit selector. A 2-bit instruction-fetch break timing field is stored here and driven straight to the core; it has no effect inside the block. The block has two reset inputs. A full reset clears everything. A warm reset keeps the register but stops the trigger. No data flows through the block, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `brk_ctrl_reg`

## Requirements
- R1: Read bits 31:18, 11:8 and 5:0 always return 0, whatever value was written to them.
- R2: Bits 17:16 hold a read/write width select that sets the trigger pulse length: 00 gives 1 cycle, 01 gives 2, 10 gives 4 and 11 gives 8.
- R3: Bits 15:12 hold match flags, with bit 12+i tied to match_i[i]. A write with a 1 in a flag's bit leaves that flag unchanged.
- R4: A write with a 0 in a flag's bit clears that flag. Writing 0 to one flag and 1 to the other three clears only that flag.
- R5: A one-cycle pulse on match_i[i] sets flag i, which reads back from the next cycle. If a set and a clearing write fall in the same cycle, the flag ends up set.
- R6: When rst_full_n is low, the whole register and trig_o are 0. While rst_warm_n is low, the register keeps its contents, trig_o is 0, and writes and match inputs are ignored.
- R7: When any match_i bit is high at a clock edge outside reset, trig_o is high from that edge for W cycles. W comes from the select value the register held before that edge. After that, trig_o is low unless another event arrives.
- R8: Bits 7:6 hold a read/write fetch-break timing field. Its value is driven on brk_timing_o and affects nothing else in the block.
- R9: A write to the width select during a pulse does not change the length of that pulse.
- R10: A new event during a pulse restarts the pulse with the full width W that applies at the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_full_n | input | 1 | Full reset, asynchronous, active low |
| rst_warm_n | input | 1 | Warm reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| match_i | input | 4 | Break-match event pulses, one per flag |
| rd_data | output | 32 | Current register value |
| brk_timing_o | output | 2 | Fetch-break timing field for the core |
| trig_o | output | 1 | Registered break trigger pulse |

## Verification
The assertions check these rules on every cycle: reserved read bits are zero, a match sets its flag on the next cycle, a written 1 never changes a flag, configuration holds without a write, and the trigger starts, holds and stops as its counter says. Only the bench scenarios can show the pulse lengths measured for all four select codes, and the single-flag clear pattern. The same applies to the set-over-clear tie, a select change in mid-pulse, retriggering, and how the register behaves under a warm reset compared with a full reset. A behavioural model that tracks the cycle at which the pulse ends is compared with the outputs on every clock.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int REG_W    = 32;
  localparam int FLAG_N   = 4;
  localparam int FLAG_LSB = 12;
  localparam int SEL_W    = 2;
  localparam int SEL_LSB  = 16;
  localparam int TIM_W    = 2;
  localparam int TIM_LSB  = 6;
  localparam int MAX_SPAN = 1 << ((1 << SEL_W) - 1);
  localparam int CNT_W    = $clog2(MAX_SPAN) + 1;
endpackage

// File: rtl/brk_flags.sv
module brk_flags
  import brk_pkg::*;
#(
  parameter int N = FLAG_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_bits,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_o[i] <= 1'b0;
      end else if (hold_n) begin
        if (set_i[i]) begin
          flags_o[i] <= 1'b1;
        end else if (wr_en && !wr_bits[i]) begin
          flags_o[i] <= 1'b0;
        end
      end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n || !hold_n)
      set_i[i] |=> flags_o[i]); // R5
    AST_FLAG_WR1_KEEP: assert property (@(posedge clk) disable iff (!rst_n || !hold_n)
      (wr_en && wr_bits[i] && !set_i[i]) |=> (flags_o[i] == $past(flags_o[i]))); // R3
  end
endmodule

// File: rtl/brk_cfg.sv
module brk_cfg
  import brk_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int TW = TIM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [TW-1:0] wr_tim,
  output logic [SW-1:0] sel_o,
  output logic [TW-1:0] tim_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o <= '0;
      tim_o <= '0;
    end else if (hold_n && wr_en) begin
      sel_o <= wr_sel;
      tim_o <= wr_tim;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !hold_n) |=> ($stable(sel_o) && $stable(tim_o))); // R6
endmodule

// File: rtl/brk_trig.sv
module brk_trig
  import brk_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic [SW-1:0] sel_i,
  output logic          trig_o
);
  logic [CW-1:0] rem_q;
  logic [CW-1:0] span_m1;

  assign span_m1 = CW'((32'd1 << sel_i) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      trig_o <= 1'b0;
    end else if (fire_i) begin
      rem_q  <= span_m1;
      trig_o <= 1'b1;
    end else if (rem_q != '0) begin
      rem_q  <= rem_q - 1'b1;
      trig_o <= 1'b1;
    end else begin
      trig_o <= 1'b0;
    end
  end

  AST_TRIG_START: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> trig_o); // R7
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q != '0) |=> trig_o); // R10
  AST_TRIG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && rem_q == '0) |=> !trig_o); // R7
endmodule

// File: rtl/brk_ctrl_reg.sv
module brk_ctrl_reg
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_full_n,
  input  logic              rst_warm_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [FLAG_N-1:0] match_i,
  output logic [REG_W-1:0]  rd_data,
  output logic [TIM_W-1:0]  brk_timing_o,
  output logic              trig_o
);
  localparam logic [REG_W-1:0] LIVE_MASK =
      (((REG_W'(1) << FLAG_N) - 1) << FLAG_LSB) |
      (((REG_W'(1) << SEL_W) - 1) << SEL_LSB) |
      (((REG_W'(1) << TIM_W) - 1) << TIM_LSB);

  logic              rst_any_n;
  logic              fire;
  logic [FLAG_N-1:0] flags;
  logic [SEL_W-1:0]  sel;
  logic [TIM_W-1:0]  tim;

  assign rst_any_n = rst_full_n & rst_warm_n;
  assign fire      = (|match_i) & rst_warm_n;

  brk_flags #(.N(FLAG_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_full_n),
    .hold_n  (rst_warm_n),
    .wr_en   (wr_en),
    .wr_bits (wr_data[FLAG_LSB +: FLAG_N]),
    .set_i   (match_i),
    .flags_o (flags)
  );

  brk_cfg #(.SW(SEL_W), .TW(TIM_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_full_n),
    .hold_n (rst_warm_n),
    .wr_en  (wr_en),
    .wr_sel (wr_data[SEL_LSB +: SEL_W]),
    .wr_tim (wr_data[TIM_LSB +: TIM_W]),
    .sel_o  (sel),
    .tim_o  (tim)
  );

  brk_trig #(.SW(SEL_W), .CW(CNT_W)) u_trig (
    .clk    (clk),
    .rst_n  (rst_any_n),
    .fire_i (fire),
    .sel_i  (sel),
    .trig_o (trig_o)
  );

  always_comb begin
    rd_data = '0;
    rd_data[FLAG_LSB +: FLAG_N] = flags;
    rd_data[SEL_LSB +: SEL_W]   = sel;
    rd_data[TIM_LSB +: TIM_W]   = tim;
  end

  assign brk_timing_o = tim;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_full_n)
    ((rd_data & ~LIVE_MASK) == '0)); // R1
endmodule

// File: tb/tb_brk_ctrl_reg.sv
module tb_brk_ctrl_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_full_n = 1'b0;
  logic        rst_warm_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  match_i = '0;
  logic [31:0] rd_data;
  logic [1:0]  brk_timing_o;
  logic        trig_o;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_ctrl_reg dut (
    .clk(clk), .rst_full_n(rst_full_n), .rst_warm_n(rst_warm_n),
    .wr_en(wr_en), .wr_data(wr_data), .match_i(match_i),
    .rd_data(rd_data), .brk_timing_o(brk_timing_o), .trig_o(trig_o)
  );

  // Behavioural model: the pulse is tracked as the cycle number where it ends.
  int       cyc = 0;
  int       until_cyc = 0;
  bit [3:0] m_flags = '0;
  bit [1:0] m_sel = '0;
  bit [1:0] m_tim = '0;

  always @(posedge clk) begin
    int width;
    cyc++;
    if (!rst_full_n) begin
      m_flags = '0; m_sel = '0; m_tim = '0; until_cyc = 0;
    end else if (!rst_warm_n) begin
      until_cyc = 0;
    end else begin
      width = 1 << m_sel;
      if (wr_en) begin
        m_sel = wr_data[17:16];
        m_tim = wr_data[7:6];
        m_flags = m_flags & wr_data[15:12];
      end
      m_flags = m_flags | match_i;
      if (match_i != 0) until_cyc = cyc + width;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    if (!cmp_on) return;
    check("R1 reserved", rd_data & ~32'h0003_F0C0, 32'h0);
    check("R2 select", 32'(rd_data[17:16]), 32'(m_sel));
    check("R3 flags", 32'(rd_data[15:12]), 32'(m_flags));
    check("R8 timing", {28'h0, brk_timing_o, rd_data[7:6]}, {28'h0, m_tim, m_tim});
    check("R7 trig", 32'(trig_o), 32'(cyc < until_cyc));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(logic [3:0] m);
    match_i = m;
    tick();
    match_i = '0;
  endtask

  task automatic measure(int sel, string req);
    int hi = 0;
    wr(32'(sel) << 16 | 32'h0000_F000);
    pulse(4'b0001);
    if (trig_o) hi++;
    for (int k = 0; k < 12; k++) begin
      tick();
      if (trig_o) hi++;
    end
    check(req, 32'(hi), 32'(1 << sel));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 full reset value", rd_data, 32'h0);
    check("R6 full reset trig", 32'(trig_o), 32'h0);
    rst_full_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;

    // R1: reserved bits ignore an all-ones write
    wr(32'hFFFF_FFFF);
    check("R1 all-ones write", rd_data, 32'h0003_00C0);
    // R8: timing field stored, no pulse produced
    wr(32'h0000_F080);
    check("R8 timing value", 32'(brk_timing_o), 32'h2);
    check("R8 no trig", 32'(trig_o), 32'h0);

    // R2/R7: pulse widths for each select code
    measure(0, "R2 width sel=00");
    measure(1, "R2 width sel=01");
    measure(2, "R2 width sel=10");
    measure(3, "R2 width sel=11");

    // R3/R5: set flags, writing 1 keeps them
    pulse(4'b0101);
    check("R5 flags set", 32'(rd_data[15:12]), 32'h5);
    wr(32'h0003_F000);
    check("R3 write one keeps", 32'(rd_data[15:12]), 32'h5);
    pulse(4'b1010);
    repeat (10) tick();
    // R4: clear flag 1 only
    wr(32'h0003_D000);
    check("R4 single clear", 32'(rd_data[15:12]), 32'hD);
    // R5: set wins over clear in same cycle
    match_i = 4'b0001; wr(32'h0003_0000); match_i = '0;
    check("R5 set beats clear", 32'(rd_data[15:12]), 32'h1);
    repeat (10) tick();

    // R9: select change mid-pulse does not alter the pulse
    wr(32'h0002_F000);
    pulse(4'b0010);
    wr(32'h0000_F000);
    repeat (2) tick();
    check("R9 still high", 32'(trig_o), 32'h1);
    tick();
    check("R9 ends at 4", 32'(trig_o), 32'h0);

    // R10: retrigger restarts full width
    wr(32'h0002_F000);
    pulse(4'b0100);
    tick(); tick();
    pulse(4'b0100);
    repeat (3) tick();
    check("R10 restarted", 32'(trig_o), 32'h1);
    tick();
    check("R10 ends", 32'(trig_o), 32'h0);

    // R6: warm reset mid-pulse
    wr(32'h0003_F040);
    pulse(4'b1000);
    rst_warm_n = 1'b0;
    #1;
    check("R6 warm trig low", 32'(trig_o), 32'h0);
    wr(32'h0000_0000);
    pulse(4'b0001);
    check("R6 warm keeps reg", rd_data, 32'h0003_F040);
    rst_warm_n = 1'b1;
    repeat (10) tick();
    check("R6 warm released", rd_data, 32'h0003_F040);
    rst_full_n = 1'b0;
    #1;
    check("R6 full clears", rd_data, 32'h0);
    tick();
    rst_full_n = 1'b1;
    repeat (3) tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule